// File: doc/BRIEF.md
# Serial Clock Pulse Count Guard

This block protects a serial-access memory from frames that arrive misaligned, for example when noise on the serial clock line adds an extra edge. It watches the chip-select input and a pulse marking each rising edge of the serial clock. From the moment the command decoder signals a detected start bit until chip select falls, the block counts the rising edges of the serial clock.

When chip select falls, the count is compared with the exact frame length that the decoded command and the memory organisation call for. That length is the start bit, two opcode bits, the address field and, for commands that carry data, the data field. A command that modifies memory gets one of two single-cycle pulses: a commit pulse when the count matches, or an abort pulse when it does not.

The memory controller uses these pulses to start the self-timed program cycle or to drop it. Commands that do not modify memory pass through without a decision.

Top module: `cpg_frame_guard`

## Requirements
- R1: After reset, `commit_o` and `abort_o` are both 0.
- R2: The edge that carries the start bit counts as one. This holds when `start_i` and `edge_i` are high in the same cycle. Each later `edge_i` pulse seen while `sel_i` is high adds one. An `edge_i` in the cycle where `sel_i` is already low is not counted.
- R3: The expected length is 3 plus the address width plus the data width. The data width applies only to write (code 2) and write-all (code 3). With the defaults this gives 18 for byte organisation (`org_i`=0, 7 address bits, 8 data bits) and 25 for word organisation (`org_i`=1, 6 address bits, 16 data bits).
- R4: Erase (code 4) and erase-all (code 5) expect 10 edges for byte organisation and 9 for word organisation.
- R5: For codes 2 to 5, a count equal to the expected length gives a commit pulse, and any other count gives an abort pulse. This includes a count one above the expected length, which is what a single clock glitch produces.
- R6: Codes 0 (idle), 1 (read), 6 (write enable) and 7 (write disable) never produce either pulse, whatever the count.
- R7: The decision appears in the cycle after the first cycle with `sel_i` low. It lasts exactly one cycle, and `commit_o` and `abort_o` are never high together.
- R8: The counter saturates at its all-ones value. With the default widths (6 bits), 89 edges give an abort and never wrap around to a false match.
- R9: A frame in which no start pulse was seen produces no pulse.
- R10: `cmd_i` and `org_i` are taken in the cycle where `sel_i` is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, synchronised |
| edge_i | input | 1 | One-cycle pulse per serial clock rising edge |
| start_i | input | 1 | One-cycle pulse when the start bit is detected |
| cmd_i | input | 3 | Decoded command code |
| org_i | input | 1 | Organisation: 0 byte, 1 word |
| commit_o | output | 1 | Pulse: modifying frame had the exact length |
| abort_o | output | 1 | Pulse: modifying frame length mismatched |

## Verification
Two functions of the block can coincide in one cycle.

The first is the start pulse and a clock edge. Every frame in the bench raises both in the same cycle. The exact-length cases then have to commit, which shows that the start edge is counted once and not twice.

The second is the fall of chip select and a clock edge. The bench sends a correct-length write with one more edge placed in the first low cycle of chip select. A commit is expected, because that late edge must not be counted.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_READ   = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_WRALL  = 3'd3,
    CMD_ERASE  = 3'd4,
    CMD_ERALL  = 3'd5,
    CMD_WREN   = 3'd6,
    CMD_WRDIS  = 3'd7
  } cpg_cmd_e;

  function automatic logic cmd_is_gated(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_WRALL) ||
           (c == CMD_ERASE) || (c == CMD_ERALL);
  endfunction

  function automatic logic cmd_has_data(input logic [2:0] c);
    return (c == CMD_WRITE) || (c == CMD_WRALL);
  endfunction
endpackage

// File: rtl/cpg_edge_count.sv
module cpg_edge_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             edge_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             fall_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             sel_q;
  logic             fall;
  logic             load, bump;

  assign fall = sel_q & ~sel_i;
  assign load = start_i & sel_i;
  assign bump = armed_q & sel_i & edge_i & ~start_i & (cnt_q != SAT);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (fall) begin
      armed_d = 1'b0;
    end else if (load) begin
      armed_d = 1'b1;
    end
    if (load) begin
      cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (bump) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      sel_q   <= sel_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
  assign fall_o  = fall;

  // R2
  edge_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sel_i && edge_i && !start_i && cnt_q != SAT)
      |=> cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1});

  // R8
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT && !start_i) |=> cnt_q == SAT);
endmodule

// File: rtl/cpg_len_table.sv
module cpg_len_table
  import cpg_pkg::*;
#(
  parameter int ADDR_BYTE = 7,
  parameter int ADDR_WORD = 6,
  parameter int DATA_BYTE = 8,
  parameter int DATA_WORD = 16,
  parameter int CNT_W     = 6
) (
  input  logic [2:0]       cmd_i,
  input  logic             org_i,
  output logic [CNT_W-1:0] exp_len_o,
  output logic             gated_o
);
  localparam int HDR = 3;
  localparam logic [CNT_W-1:0] LEN_CTL_B = CNT_W'(HDR + ADDR_BYTE);
  localparam logic [CNT_W-1:0] LEN_CTL_W = CNT_W'(HDR + ADDR_WORD);
  localparam logic [CNT_W-1:0] LEN_DAT_B = CNT_W'(HDR + ADDR_BYTE + DATA_BYTE);
  localparam logic [CNT_W-1:0] LEN_DAT_W = CNT_W'(HDR + ADDR_WORD + DATA_WORD);

  always_comb begin
    gated_o = cmd_is_gated(cmd_i);
    unique case ({cmd_has_data(cmd_i), org_i})
      2'b00:   exp_len_o = LEN_CTL_B;
      2'b01:   exp_len_o = LEN_CTL_W;
      2'b10:   exp_len_o = LEN_DAT_B;
      default: exp_len_o = LEN_DAT_W;
    endcase
  end
endmodule

// File: rtl/cpg_frame_guard.sv
module cpg_frame_guard
  import cpg_pkg::*;
#(
  parameter int ADDR_BYTE = 7,
  parameter int ADDR_WORD = 6,
  parameter int DATA_BYTE = 8,
  parameter int DATA_WORD = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       edge_i,
  input  logic       start_i,
  input  logic [2:0] cmd_i,
  input  logic       org_i,
  output logic       commit_o,
  output logic       abort_o
);
  localparam int LEN_B   = 3 + ADDR_BYTE + DATA_BYTE;
  localparam int LEN_W   = 3 + ADDR_WORD + DATA_WORD;
  localparam int MAX_LEN = (LEN_B > LEN_W) ? LEN_B : LEN_W;
  localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;

  logic [CNT_W-1:0] cnt, exp_len;
  logic             armed, fall, gated, decide;
  logic             commit_q, commit_d, abort_q, abort_d;

  cpg_edge_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .edge_i  (edge_i),
    .start_i (start_i),
    .cnt_o   (cnt),
    .armed_o (armed),
    .fall_o  (fall)
  );

  cpg_len_table #(
    .ADDR_BYTE (ADDR_BYTE),
    .ADDR_WORD (ADDR_WORD),
    .DATA_BYTE (DATA_BYTE),
    .DATA_WORD (DATA_WORD),
    .CNT_W     (CNT_W)
  ) u_len (
    .cmd_i     (cmd_i),
    .org_i     (org_i),
    .exp_len_o (exp_len),
    .gated_o   (gated)
  );

  assign decide = fall & armed & gated;

  always_comb begin
    commit_d = decide & (cnt == exp_len);
    abort_d  = decide & (cnt != exp_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      commit_q <= commit_d;
      abort_q  <= abort_d;
    end
  end

  assign commit_o = commit_q;
  assign abort_o  = abort_q;

  // R7
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_o, abort_o}));

  // R7
  after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || abort_o) |-> (!$past(sel_i) && $past(sel_i, 2)));

  // R7
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || abort_o) |=> !(commit_o || abort_o));

  // R6
  ungated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !gated) |=> !(commit_o || abort_o));
endmodule

// File: tb/cpg_frame_guard_tb_top.sv
module cpg_frame_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, edg, start, org;
  logic [2:0] cmd;
  logic       commit, abort;
  int         total = 0;
  int         bad   = 0;

  always #2 clk = ~clk;

  cpg_frame_guard dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sel_i    (sel),
    .edge_i   (edg),
    .start_i  (start),
    .cmd_i    (cmd),
    .org_i    (org),
    .commit_o (commit),
    .abort_o  (abort)
  );

  // {cmd[2:0], org, edges[7:0], expect[1:0]}; expect 0 none, 1 commit, 2 abort
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {3'd2, 1'b0, 8'd18, 2'd1},  // R3 write byte
    {3'd2, 1'b0, 8'd19, 2'd2},  // R5 glitch
    {3'd2, 1'b0, 8'd17, 2'd2},  // R5 short
    {3'd2, 1'b1, 8'd25, 2'd1},  // R3 write word
    {3'd2, 1'b1, 8'd18, 2'd2},  // R5 wrong org length
    {3'd3, 1'b0, 8'd18, 2'd1},  // R3 write-all byte
    {3'd3, 1'b1, 8'd25, 2'd1},  // R3 write-all word
    {3'd4, 1'b0, 8'd10, 2'd1},  // R4 erase byte
    {3'd4, 1'b1, 8'd9,  2'd1},  // R4 erase word
    {3'd4, 1'b1, 8'd10, 2'd2},  // R5 erase glitch
    {3'd5, 1'b0, 8'd10, 2'd1},  // R4 erase-all byte
    {3'd5, 1'b1, 8'd11, 2'd2},  // R5 erase-all long
    {3'd1, 1'b0, 8'd30, 2'd0},  // R6 read
    {3'd6, 1'b1, 8'd9,  2'd0},  // R6 enable
    {3'd7, 1'b0, 8'd3,  2'd0},  // R6 disable
    {3'd6, 1'b0, 8'd50, 2'd0}   // R6 enable long
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual={abort,commit}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] c, input logic o, input int n,
                       input logic with_start, input logic tail_edge,
                       input logic [2:0] c_at_fall, output logic [1:0] res);
    @(negedge clk);
    cmd = c; org = o; sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      edg = 1'b1; start = with_start && (i == 0);
      @(negedge clk);
      edg = 1'b0; start = 1'b0;
    end
    @(negedge clk);
    sel = 1'b0; edg = tail_edge; cmd = c_at_fall;
    @(negedge clk);
    edg = 1'b0;
    res = {abort, commit};
    @(negedge clk);
    check("R7 pulse width", {abort, commit}, 2'b00);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] r;
    rst_n = 1'b0; sel = 1'b0; edg = 1'b0; start = 1'b0; cmd = 3'd0; org = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {abort, commit}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {abort, commit}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][13:11], VEC[v][10], int'(VEC[v][9:2]), 1'b1, 1'b0, VEC[v][13:11], r);
      case (VEC[v][1:0])
        2'd1:    check("R3/R4/R5 vector", r, 2'b01);
        2'd2:    check("R5 vector", r, 2'b10);
        default: check("R6 vector", r, 2'b00);
      endcase
    end

    // R8 saturation: 89 would wrap to 25 in 6 bits
    frame(3'd2, 1'b1, 89, 1'b1, 1'b0, 3'd2, r);
    check("R8 saturate", r, 2'b10);
    // R2 edge in fall cycle not counted
    frame(3'd2, 1'b0, 18, 1'b1, 1'b1, 3'd2, r);
    check("R2 fall-cycle edge", r, 2'b01);
    frame(3'd4, 1'b1, 8, 1'b1, 1'b1, 3'd4, r);
    check("R2 fall-cycle edge short", r, 2'b10);
    // R9 no start
    frame(3'd2, 1'b0, 18, 1'b0, 1'b0, 3'd2, r);
    check("R9 no start", r, 2'b00);
    // R10 command taken at fall: 10 edges, read at start, erase at fall
    frame(3'd1, 1'b0, 10, 1'b1, 1'b0, 3'd4, r);
    check("R10 cmd at fall", r, 2'b01);
    frame(3'd4, 1'b0, 10, 1'b1, 1'b0, 3'd6, r);
    check("R10 ungated at fall", r, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule